// File: doc/BRIEF.md
# Butterfly Address-Pair Sequencer

This block drives the memory side of an in-place radix-2 decimation-in-frequency transform engine that runs a forward pass and then an inverse pass over one frame of N = 2^pow complex samples. A single start pulse latches the size exponent. The block then walks the whole iteration schedule and issues one butterfly operand pair (s, t) per clock. The schedule is the forward iterations, then one iteration shared by the last forward and first inverse step, then the remaining inverse iterations. Each address comes from a counter value rotated cyclically to the right inside an n-bit field. The rotation amount changes from one iteration to the next.

The engine stores samples in two single-read-port banks. The bit-parity of an index selects its bank, so the two operands of any butterfly always sit in different banks. The block computes parity(s). When it is 1, the block swaps the pair so that the even-parity address always goes to bank 0 and the odd-parity address to bank 1. It also outputs the parity with the pair, so the data crossbars downstream can undo the swap on read and on write-back. Sample k is loaded into and unloaded from bank parity(k) under the same rule. Iteration index, a pair strobe and an end-of-schedule pulse complete the interface.

Top module: `bfly_addr_gen`

## Requirements
- R1: A start pulse seen while idle is accepted only if pow is between 3 and 10 inclusive. A start with any other pow yields no pair strobe and no done pulse.
- R2: For butterfly i (0 to N/2-1) of an iteration with rotation r, s is i rotated right by r within n = pow bits, and t is i + N/2 rotated the same way. Both are below N.
- R3: There are 2n-1 iterations, numbered 0 to 2n-2 on iter_idx. Iteration k uses rotation k for k < n and rotation 2n-2-k otherwise. For n = 4 the rotations are 0,1,2,3,2,1,0.
- R4: Inside an iteration the pairs come in increasing i, one per clock with no gaps, and iter_idx is constant.
- R5: bank0_addr always has even bit-parity and bank1_addr odd bit-parity. swap equals parity(s): with swap = 1, bank0_addr = t and bank1_addr = s; with swap = 0, bank0_addr = s and bank1_addr = t.
- R6: The first pair is presented in the cycle after the second rising edge that follows the edge sampling start. Exactly one cycle without pair_valid separates consecutive iterations.
- R7: done is high for exactly one cycle, the cycle right after the final pair of the final iteration, with pair_valid low.
- R8: A start pulse that arrives while a schedule is running, with any pow, has no effect on the running schedule.
- R9: While reset is high and in the cycle after it, pair_valid, done, swap, iter_idx and both addresses are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Begin a schedule (sampled while idle) |
| pow | input | 4 | Size exponent n, latched on an accepted start |
| bank0_addr | output | 10 | Even-parity operand address for bank 0 |
| bank1_addr | output | 10 | Odd-parity operand address for bank 1 |
| swap | output | 1 | parity(s); 1 means t is on bank 0 |
| iter_idx | output | 5 | Iteration number of the presented pair |
| pair_valid | output | 1 | A pair is presented this cycle |
| done | output | 1 | One-cycle pulse after the final pair |

## Verification
The bench builds the block with its default parameters: a maximum exponent of 10 and a 10-bit address field. With these, every runtime size from 8 to 1024 points can be requested, and the bench runs each one back to back. Because the widest size fills the whole address field, the rotation mask at full width and the largest counter values, up to 1023, are both exercised. The smallest size gives iterations of only four pairs, where a busy start is injected and the one-cycle gaps and the done pulse fall close together.

// File: rtl/bag_pkg.sv
package bag_pkg;
  typedef enum logic [1:0] {
    ST_IDLE,
    ST_LOAD,
    ST_ISSUE,
    ST_FINISH
  } bag_state_e;
endpackage

// File: rtl/bag_rotor.sv
module bag_rotor #(
  parameter int AW = 10,
  parameter int PW = 4
) (
  input  logic [AW-1:0] val,
  input  logic [PW-1:0] width_n,
  input  logic [PW-1:0] amt,
  output logic [AW-1:0] rotated
);
  localparam int DW = 2 * AW;

  logic [DW-1:0] dbl;
  logic [DW-1:0] mask;

  always_comb begin
    dbl     = ({{AW{1'b0}}, val} << width_n) | {{AW{1'b0}}, val};
    dbl     = dbl >> amt;
    mask    = ({{(DW-1){1'b0}}, 1'b1} << width_n) - {{(DW-1){1'b0}}, 1'b1};
    rotated = dbl[AW-1:0] & mask[AW-1:0];
  end
endmodule

// File: rtl/bag_seq.sv
module bag_seq
  import bag_pkg::*;
#(
  parameter int MIN_POW = 3,
  parameter int MAX_POW = 10,
  parameter int AW      = MAX_POW,
  parameter int PW      = $clog2(MAX_POW + 1),
  parameter int IW      = $clog2(2 * MAX_POW - 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic [PW-1:0] pow,
  output logic          issue,
  output logic [AW-1:0] cnt_lo,
  output logic [AW-1:0] cnt_hi,
  output logic [PW-1:0] rot_amt,
  output logic [PW-1:0] pow_q,
  output logic [IW-1:0] iter,
  output logic          done
);
  bag_state_e   state;
  logic [AW-1:0] half;
  logic [AW-1:0] lo_last;
  logic [IW-1:0] pow_iw;
  logic [IW-1:0] iter_last;
  logic [IW-1:0] rot_next;
  logic          pow_ok;

  assign half      = {{(AW-1){1'b0}}, 1'b1} << (pow_q - {{(PW-1){1'b0}}, 1'b1});
  assign lo_last   = half - {{(AW-1){1'b0}}, 1'b1};
  assign pow_iw    = IW'(pow_q);
  assign iter_last = (pow_iw << 1) - IW'(2);
  assign rot_next  = (iter < pow_iw) ? iter : (iter_last - iter);
  assign pow_ok    = (pow >= PW'(MIN_POW)) && (pow <= PW'(MAX_POW));
  assign issue     = (state == ST_ISSUE);

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= ST_IDLE;
      cnt_lo  <= '0;
      cnt_hi  <= '0;
      rot_amt <= '0;
      pow_q   <= PW'(MIN_POW);
      iter    <= '0;
      done    <= 1'b0;
    end else begin
      done <= (state == ST_FINISH);
      case (state)
        ST_IDLE: begin
          if (start && pow_ok) begin
            pow_q <= pow;
            iter  <= '0;
            state <= ST_LOAD;
          end
        end
        ST_LOAD: begin
          cnt_lo  <= '0;
          cnt_hi  <= half;
          rot_amt <= PW'(rot_next);
          state   <= ST_ISSUE;
        end
        ST_ISSUE: begin
          cnt_lo <= cnt_lo + {{(AW-1){1'b0}}, 1'b1};
          cnt_hi <= cnt_hi + {{(AW-1){1'b0}}, 1'b1};
          if (cnt_lo == lo_last) begin
            if (iter == iter_last) begin
              state <= ST_FINISH;
            end else begin
              iter  <= iter + {{(IW-1){1'b0}}, 1'b1};
              state <= ST_LOAD;
            end
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R2: the upper counter runs exactly half a frame ahead of the lower one
  p_counter_gap_r2: assert property (@(posedge clk) disable iff (rst)
    (state == ST_ISSUE) |-> ((cnt_hi - cnt_lo) == half));

  // R1: a running schedule only ever holds a supported size
  p_size_range_r1: assert property (@(posedge clk) disable iff (rst)
    (state != ST_IDLE) |-> (pow_q >= PW'(MIN_POW) && pow_q <= PW'(MAX_POW)));

  // R8: the latched size cannot change while busy
  p_busy_hold_r8: assert property (@(posedge clk) disable iff (rst)
    (state != ST_IDLE) |=> $stable(pow_q));

  // R3: rotation never reaches the field width
  p_rot_bound_r3: assert property (@(posedge clk) disable iff (rst)
    (state == ST_ISSUE) |-> (rot_amt < pow_q));
endmodule

// File: rtl/bfly_addr_gen.sv
module bfly_addr_gen #(
  parameter int MIN_POW = 3,
  parameter int MAX_POW = 10,
  parameter int AW      = MAX_POW,
  parameter int PW      = $clog2(MAX_POW + 1),
  parameter int IW      = $clog2(2 * MAX_POW - 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic [PW-1:0] pow,
  output logic [AW-1:0] bank0_addr,
  output logic [AW-1:0] bank1_addr,
  output logic          swap,
  output logic [IW-1:0] iter_idx,
  output logic          pair_valid,
  output logic          done
);
  localparam int LANES = 2;

  logic          issue;
  logic [AW-1:0] cnt_lo;
  logic [AW-1:0] cnt_hi;
  logic [PW-1:0] rot_amt;
  logic [PW-1:0] pow_q;
  logic [IW-1:0] iter;
  logic [AW-1:0] lane_in  [LANES];
  logic [AW-1:0] lane_out [LANES];
  logic          s_par;

  bag_seq #(
    .MIN_POW(MIN_POW), .MAX_POW(MAX_POW), .AW(AW), .PW(PW), .IW(IW)
  ) seq_i (
    .clk(clk), .rst(rst), .start(start), .pow(pow),
    .issue(issue), .cnt_lo(cnt_lo), .cnt_hi(cnt_hi),
    .rot_amt(rot_amt), .pow_q(pow_q), .iter(iter), .done(done)
  );

  assign lane_in[0] = cnt_lo;
  assign lane_in[1] = cnt_hi;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    bag_rotor #(.AW(AW), .PW(PW)) rot_i (
      .val(lane_in[g]), .width_n(pow_q), .amt(rot_amt), .rotated(lane_out[g])
    );
  end

  assign s_par = ^lane_out[0];

  always_ff @(posedge clk) begin
    if (rst) begin
      bank0_addr <= '0;
      bank1_addr <= '0;
      swap       <= 1'b0;
      iter_idx   <= '0;
      pair_valid <= 1'b0;
    end else begin
      pair_valid <= issue;
      if (issue) begin
        bank0_addr <= s_par ? lane_out[1] : lane_out[0];
        bank1_addr <= s_par ? lane_out[0] : lane_out[1];
        swap       <= s_par;
        iter_idx   <= iter;
      end
    end
  end

  // R5: banks always receive opposite-parity addresses, even on bank 0
  p_bank_split_r5: assert property (@(posedge clk) disable iff (rst)
    pair_valid |-> (!(^bank0_addr) && (^bank1_addr)));

  // R2: both addresses lie inside the active frame
  p_addr_range_r2: assert property (@(posedge clk) disable iff (rst)
    pair_valid |-> (((bank0_addr | bank1_addr) >> pow_q) == '0));

  // R4: back-to-back pairs belong to the same iteration
  p_iter_hold_r4: assert property (@(posedge clk) disable iff (rst)
    (pair_valid && $past(pair_valid)) |-> (iter_idx == $past(iter_idx)));

  // R7: done is a single-cycle pulse that follows a pair
  p_done_pulse_r7: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
  p_done_follow_r7: assert property (@(posedge clk) disable iff (rst)
    done |-> (!pair_valid && $past(pair_valid)));
endmodule

// File: tb/bfly_addr_gen_tb.sv
module bfly_addr_gen_tb_top;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       start = 1'b0;
  logic [3:0] pow = 4'd0;
  logic [9:0] bank0_addr;
  logic [9:0] bank1_addr;
  logic       swap;
  logic [4:0] iter_idx;
  logic       pair_valid;
  logic       done;

  int total = 0;
  int bad   = 0;

  always #5 clk = ~clk;

  bfly_addr_gen dut_i (
    .clk(clk), .rst(rst), .start(start), .pow(pow),
    .bank0_addr(bank0_addr), .bank1_addr(bank1_addr), .swap(swap),
    .iter_idx(iter_idx), .pair_valid(pair_valid), .done(done)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int rot_ref(input int v, input int r, input int n);
    int res = 0;
    for (int b = 0; b < n; b++)
      if ((v >> b) & 1) res |= 1 << ((b - r + n) % n);
    return res;
  endfunction

  function automatic int par_ref(input int v);
    return $countones(v) & 1;
  endfunction

  task automatic t_reset();
    rst = 1'b1;
    start = 1'b1;
    pow = 4'd4;
    repeat (3) @(negedge clk);
    chk(pair_valid == 0 && done == 0, "R9 valid/done in reset", {pair_valid, done}, 0);
    chk(bank0_addr == 0 && bank1_addr == 0, "R9 addresses in reset", bank0_addr + bank1_addr, 0);
    start = 1'b0;
    rst = 1'b0;
    @(negedge clk);
    chk(swap == 0 && iter_idx == 0 && pair_valid == 0, "R9 after release",
        {swap, iter_idx, pair_valid}, 0);
  endtask

  task automatic t_run(input int p, input bit inject);
    int half = 1 << (p - 1);
    int last = 2 * p - 2;
    @(negedge clk);
    start = 1'b1;
    pow = 4'(p);
    @(negedge clk);
    start = 1'b0;
    chk(pair_valid == 0, "R6 no pair one cycle after start", pair_valid, 0);
    @(negedge clk);
    chk(pair_valid == 0, "R6 no pair two cycles after start", pair_valid, 0);
    for (int it = 0; it <= last; it++) begin
      int r = (it < p) ? it : last - it;
      for (int i = 0; i < half; i++) begin
        int s = rot_ref(i, r, p);
        int t = rot_ref(i + half, r, p);
        int e0 = par_ref(s) ? t : s;
        int e1 = par_ref(s) ? s : t;
        @(negedge clk);
        if (inject && it == 1 && i == 1) start = 1'b0;
        chk(pair_valid == 1 && done == 0, "R4 contiguous pair strobe", pair_valid, 1);
        chk(bank0_addr == 10'(e0), "R2 bank0 address", bank0_addr, e0);
        chk(bank1_addr == 10'(e1), "R2 bank1 address", bank1_addr, e1);
        chk(swap == 1'(par_ref(s)), "R5 swap flag", swap, par_ref(s));
        chk(par_ref(bank0_addr) == 0 && par_ref(bank1_addr) == 1, "R5 bank parity",
            par_ref(bank0_addr), 0);
        chk(iter_idx == 5'(it), "R3 iteration index", iter_idx, it);
        if (inject && it == 1 && i == 0) begin
          start = 1'b1;
          pow = 4'd3;
        end
      end
      @(negedge clk);
      if (it < last) begin
        chk(pair_valid == 0 && done == 0, "R6 one-cycle gap", pair_valid, 0);
      end else begin
        chk(done == 1 && pair_valid == 0, "R7 done after final pair", done, 1);
      end
    end
    @(negedge clk);
    chk(done == 0 && pair_valid == 0, "R7 done lasts one cycle", done, 0);
    if (inject) begin
      repeat (4) @(negedge clk);
      chk(pair_valid == 0, "R8 busy start left no run behind", pair_valid, 0);
    end
  endtask

  task automatic t_bad_pow(input int p);
    bit seen = 0;
    @(negedge clk);
    start = 1'b1;
    pow = 4'(p);
    @(negedge clk);
    start = 1'b0;
    repeat (30) begin
      @(negedge clk);
      if (pair_valid || done) seen = 1;
    end
    chk(!seen, "R1 unsupported size ignored", seen, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    t_reset();
    t_bad_pow(2);
    t_bad_pow(11);
    t_bad_pow(0);
    for (int p = 3; p <= 10; p++) t_run(p, 1'b0);
    t_run(3, 1'b1);
    t_run(4, 1'b1);
    t_bad_pow(15);
    t_run(10, 1'b0);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule